// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a processor core in reset after power is applied until the supply and the selected clock source can be trusted. Once a power-on pulse ends, a power-up timer clocked by the internal RC oscillator counts a fixed number of cycles. It cannot be bypassed.

In the meantime, when the primary oscillator runs in a crystal mode, a start-up qualifier counts that oscillator's own rising edges. This shows that the crystal has settled. In external-clock mode the qualifier is skipped. The qualifier's done flag crosses into the RC domain through a synchronizer. When both conditions hold, a short final delay runs, and then the core reset is released.

A new power-on pulse at any point clears every counter and starts the whole sequence again. A two-bit phase output reports where the sequence stands.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por` is high, `core_rst_n` is 0 and `phase` is 0. Phase codes: 0 = power-up timer, 1 = waiting for oscillator start-up, 2 = final delay, 3 = released.
- R2: After `por` falls, `phase` stays 0 for exactly `PWR_CYCLES` rising edges of `rc_clk`, in every oscillator mode. It then moves to 1 or 2, never to 3.
- R3: With `xtal_mode` = 1, `phase` does not reach 2 until `OST_CYCLES` (default 1024) rising edges of `osc_clk` have occurred since `por` fell. Until then it waits in phase 1. Phase 2 follows within a few `rc_clk` cycles of that count.
- R4: The start-up done flag passes through `SYNC_STAGES` (two) `rc_clk` flops. If that flag is already set when the power-up timer ends, `phase` goes straight from 0 to 2 and skips phase 1.
- R5: With `xtal_mode` = 0, the start-up count is skipped. `phase` never shows 1 and goes from 0 to 2 even with `osc_clk` stopped.
- R6: Phase 2 lasts exactly `FINAL_CYCLES` `rc_clk` edges, after which `phase` becomes 3 and `core_rst_n` becomes 1. `core_rst_n` is 1 only in phase 3.
- R7: Once released, `phase` stays 3 and `core_rst_n` stays 1 until the next `por`.
- R8: A `por` pulse during any phase immediately returns `phase` to 0 and `core_rst_n` to 0. It clears all counters, so the full sequence runs again with full lengths.
- R9: `osc_ready` is 1 in external-clock mode. In crystal mode it is the synchronized start-up done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rc_clk | input | 1 | Internal RC oscillator clock; clocks the sequencer |
| osc_clk | input | 1 | Primary oscillator clock being qualified |
| por | input | 1 | Power-on reset pulse, active high, asynchronous |
| xtal_mode | input | 1 | 1 = crystal mode (start-up count applies), 0 = external clock |
| core_rst_n | output | 1 | Core reset, low while held, high when released |
| phase | output | 2 | Current phase code (see R1) |
| osc_ready | output | 1 | Oscillator qualified flag in the RC domain |

## Verification
The assertions assume that `xtal_mode` is steady whenever `por` is low. The stimulus therefore changes the mode only while a power-on pulse is held. They also assume that `por` ends clear of an `rc_clk` edge, so the stimulus always releases it half a cycle away from the sampling edge. The primary clock is treated as free-running and unrelated to the RC clock. Two crystal speeds are driven, one that settles inside the power-up timer and one that settles well after it, plus a stopped clock in external mode.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
   typedef enum logic [1:0] {
      PH_PWRT = 2'd0,
      PH_OSTW = 2'd1,
      PH_HOLD = 2'd2,
      PH_RUN  = 2'd3
   } phase_e;
endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwrup_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrup_osc_qual.sv
module pwrup_osc_qual #(
   parameter int unsigned CYCLES = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic done
);
   if (CYCLES == 0) begin : g_none
      assign done = 1'b1;
   end else begin : g_cnt
      localparam int unsigned W = $clog2(CYCLES + 1);
      logic [W-1:0] cnt;
      logic         done_q;

      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            cnt    <= '0;
            done_q <= 1'b0;
         end else if (en && !done_q) begin
            if (cnt == W'(CYCLES - 1)) done_q <= 1'b1;
            cnt <= cnt + 1'b1;
         end
      end

      assign done = done_q;

      // R3: once the crystal is qualified it stays qualified until por
      p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
         done_q |=> done_q);
   end
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
   import pwrup_pkg::*;
#(
   parameter int unsigned PWR_CYCLES   = 2048,
   parameter int unsigned OST_CYCLES   = 1024,
   parameter int unsigned FINAL_CYCLES = 64,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       rc_clk,
   input  logic       osc_clk,
   input  logic       por,
   input  logic       xtal_mode,
   output logic       core_rst_n,
   output logic [1:0] phase,
   output logic       osc_ready
);
   localparam int unsigned MAXC = (PWR_CYCLES > FINAL_CYCLES) ? PWR_CYCLES : FINAL_CYCLES;
   localparam int unsigned CW   = $clog2(MAXC + 1);

   if (PWR_CYCLES < 1) begin : g_bad_pwr
      $error("pwrup_rst_seq: PWR_CYCLES must be at least 1");
   end
   if (FINAL_CYCLES < 1) begin : g_bad_fin
      $error("pwrup_rst_seq: FINAL_CYCLES must be at least 1");
   end

   logic    ost_done_osc;
   logic    ost_done_rc;
   logic    ost_ok;
   phase_e  st;
   logic [CW-1:0] cnt;

   pwrup_osc_qual #(.CYCLES(OST_CYCLES)) u_qual (
      .clk  (osc_clk),
      .rst  (por),
      .en   (xtal_mode),
      .done (ost_done_osc)
   );

   pwrup_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (rc_clk),
      .rst (por),
      .d   (ost_done_osc),
      .q   (ost_done_rc)
   );

   assign ost_ok = !xtal_mode || ost_done_rc;

   always_ff @(posedge rc_clk or posedge por) begin
      if (por) begin
         st  <= PH_PWRT;
         cnt <= '0;
      end else begin
         unique case (st)
            PH_PWRT: begin
               if (cnt == CW'(PWR_CYCLES - 1)) begin
                  cnt <= '0;
                  st  <= ost_ok ? PH_HOLD : PH_OSTW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_OSTW: begin
               if (ost_ok) st <= PH_HOLD;
            end
            PH_HOLD: begin
               if (cnt == CW'(FINAL_CYCLES - 1)) begin
                  cnt <= '0;
                  st  <= PH_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= PH_RUN;
         endcase
      end
   end

   assign phase      = st;
   assign core_rst_n = (st == PH_RUN);
   assign osc_ready  = ost_ok;

   // R2: the power-up timer never hands over straight to release
   p_no_skip_r2: assert property (@(posedge rc_clk) disable iff (por)
      (st == PH_PWRT) |=> (st != PH_RUN));
   // R3: the start-up wait holds until the qualified flag arrives
   p_wait_hold_r3: assert property (@(posedge rc_clk) disable iff (por)
      (st == PH_OSTW && !ost_ok) |=> (st == PH_OSTW));
   // R4: the synchronized flag never drops before the next por
   p_sync_hold_r4: assert property (@(posedge rc_clk) disable iff (por)
      ost_done_rc |=> ost_done_rc);
   // R5: external-clock mode never waits for the oscillator
   p_ext_noost_r5: assert property (@(posedge rc_clk) disable iff (por)
      !xtal_mode |-> (st != PH_OSTW));
   // R6: release only ever follows the final delay
   p_rel_gate_r6: assert property (@(posedge rc_clk) disable iff (por)
      $rose(core_rst_n) |-> ($past(st) == PH_HOLD));
   // R7: release is held until the next por
   p_run_hold_r7: assert property (@(posedge rc_clk) disable iff (por)
      (st == PH_RUN) |=> (st == PH_RUN && core_rst_n));
endmodule

// File: tb/tb_pwrup_rst_seq.sv
`timescale 1ns/1ps
module tb_pwrup_rst_seq;
   localparam int P   = 600;
   localparam int F   = 16;
   localparam int OST = 1024;

   typedef struct {
      logic [1:0] ph;
      int         lo;
      int         hi;
      bit         rel;
      string      req;
   } exp_t;

   logic       rc_clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       por = 1'b1;
   logic       xtal_mode = 1'b0;
   logic       core_rst_n;
   logic [1:0] phase;
   logic       osc_ready;

   bit osc_on = 1'b0;
   int osc_half = 5;
   int total = 0;
   int bad = 0;
   int k = 0;
   int last_chg = 0;
   int oscn = 0;
   logic [1:0] last_ph = 2'd0;
   exp_t q[$];

   pwrup_rst_seq #(.PWR_CYCLES(P), .OST_CYCLES(OST), .FINAL_CYCLES(F), .SYNC_STAGES(2)) dut (
      .rc_clk(rc_clk), .osc_clk(osc_clk), .por(por), .xtal_mode(xtal_mode),
      .core_rst_n(core_rst_n), .phase(phase), .osc_ready(osc_ready));

   always #2.5 rc_clk = ~rc_clk;

   always begin
      if (osc_on) #(osc_half) osc_clk = ~osc_clk;
      else #1;
   end

   always @(posedge osc_clk) begin
      if (por) oscn = 0;
      else     oscn = oscn + 1;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] ph, input int lo, input int hi, input bit rel, input string req);
      exp_t e;
      e.ph = ph; e.lo = lo; e.hi = hi; e.rel = rel; e.req = req;
      q.push_back(e);
   endtask

   // monitor: pops the next expected phase change and compares it
   always @(negedge rc_clk) begin
      if (por) begin
         k = 0;
         last_chg = 0;
         last_ph = phase;
      end else begin
         k = k + 1;
         if (phase != last_ph) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7", "unexpected phase change", int'(phase), int'(last_ph));
            end else begin
               exp_t e;
               int at;
               e = q.pop_front();
               at = e.rel ? (k - last_chg) : k;
               chk(phase == e.ph, e.req, "phase code", int'(phase), int'(e.ph));
               chk(at >= e.lo && at <= e.hi, e.req, "cycle of change", at, e.lo);
               chk(core_rst_n == (phase == 2'd3), "R6", "core_rst_n vs phase",
                   int'(core_rst_n), int'(phase == 2'd3));
               if (phase == 2'd2 && xtal_mode)
                  chk(oscn >= OST, "R3", "osc edges before final delay", oscn, OST);
            end
            last_chg = k;
            last_ph = phase;
         end
      end
   end

   task automatic start_por(input bit xtal, input int half);
      @(negedge rc_clk);
      #1;
      por = 1'b1;
      #1;
      chk(phase == 2'd0, "R8", "phase right after por", int'(phase), 0);
      chk(core_rst_n == 1'b0, "R8", "core_rst_n right after por", int'(core_rst_n), 0);
      q.delete();
      xtal_mode = xtal;
      osc_on = (half != 0);
      if (half != 0) osc_half = half;
      repeat (4) @(negedge rc_clk);
      chk(phase == 2'd0, "R1", "phase during por", int'(phase), 0);
      chk(core_rst_n == 1'b0, "R1", "core_rst_n during por", int'(core_rst_n), 0);
   endtask

   task automatic release_por();
      @(negedge rc_clk);
      #1;
      por = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge rc_clk);
   endtask

   task automatic push_ext();
      push(2'd2, P, P, 1'b0, "R5");
      push(2'd3, F, F, 1'b1, "R6");
   endtask

   task automatic push_slow();
      push(2'd1, P, P, 1'b0, "R3");
      push(2'd2, 2046, 2053, 1'b0, "R3");
      push(2'd3, F, F, 1'b1, "R6");
   endtask

   initial begin
      // S1: external clock, oscillator stopped
      start_por(1'b0, 0);
      push_ext();
      release_por();
      repeat (3) @(negedge rc_clk);
      chk(osc_ready == 1'b1, "R9", "osc_ready in external mode", int'(osc_ready), 1);
      drain();
      repeat (50) @(negedge rc_clk);
      chk(phase == 2'd3 && core_rst_n, "R7", "release held", int'(phase), 3);

      // S2: fast crystal settles inside the power-up timer
      start_por(1'b1, 1);
      push(2'd2, P, P, 1'b0, "R4");
      push(2'd3, F, F, 1'b1, "R6");
      release_por();
      repeat (3) @(negedge rc_clk);
      chk(osc_ready == 1'b0, "R9", "osc_ready before qualification", int'(osc_ready), 0);
      drain();
      chk(osc_ready == 1'b1, "R9", "osc_ready after qualification", int'(osc_ready), 1);

      // S3: slow crystal needs the wait phase
      start_por(1'b1, 5);
      push_slow();
      release_por();
      drain();
      repeat (10) @(negedge rc_clk);
      chk(phase == 2'd3, "R7", "released after slow crystal", int'(phase), 3);

      // S4: por during the oscillator wait restarts everything
      start_por(1'b1, 5);
      push(2'd1, P, P, 1'b0, "R2");
      release_por();
      drain();
      repeat (400) @(negedge rc_clk);
      start_por(1'b1, 5);
      push_slow();
      release_por();
      drain();

      // S5: por after release, external mode
      repeat (20) @(negedge rc_clk);
      start_por(1'b0, 0);
      push(2'd2, P, P, 1'b0, "R8");
      push(2'd3, F, F, 1'b1, "R8");
      release_por();
      drain();
      repeat (20) @(negedge rc_clk);
      chk(phase == 2'd3 && core_rst_n, "R7", "release held after restart", int'(phase), 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge rc_clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule